// File: doc/BRIEF.md
# Eight-Stage Parallel-Load Serial-Out Shift Register

This block converts a byte presented on parallel inputs into a bit stream and can also pass a serial stream straight through its eight stages. A mode select picks between a broadside load and a one-place shift. A stall input freezes all eight stages while the system clock keeps running. Only the last stage is visible outside the block.

The stall input is a synchronous clock enable inside a single clock domain. It is not a gate on the clock, so raising or lowering it never causes a state change by itself. The stream has no valid/ready handshake. The stall input is the only way to apply back-pressure: while it is high nothing moves, and the producer must keep the serial input meaningful only on edges where the block is not stalled.

An active-low clear empties the register at once, whatever the other inputs are doing. The clear is released through a two-flop synchronizer. Because of this, the first two rising edges after release leave the register at zero.

Top module: `piso_shift8`

## Requirements
- R1: While `clr_n` is low, `q_last_o` is 0.
- R2: On a rising edge with `stall_i` high, all stages keep their values, so `q_last_o` does not change, whatever `mode_shift_i`, `ser_i` and `par_i` are.
- R3: On a rising edge with `stall_i` low and `mode_shift_i` high (1 = shift), `ser_i` enters stage 0 and each stage k takes stage k-1. A serial bit therefore reaches `q_last_o` on the eighth enabled shift edge that follows its entry edge, counting the entry edge as the first.
- R4: On a rising edge with `stall_i` low and `mode_shift_i` low (0 = load), stage k takes `par_i[k]` and `ser_i` is ignored. `par_i[7]` appears at `q_last_o` at once. Later shifts present `par_i[6]` down to `par_i[0]`, one per shift.
- R5: Driving `clr_n` low between clock edges forces `q_last_o` to 0 without waiting for a clock edge.
- R6: After `clr_n` rises, the register stays at zero through the next two rising edges. The third rising edge is the first that can load or shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; all updates on its rising edge |
| clr_n | input | 1 | Active-low clear; asserts asynchronously, released synchronously |
| stall_i | input | 1 | 1 = hold all stages on this edge |
| mode_shift_i | input | 1 | 1 = shift, 0 = parallel load |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | 8 | Parallel data; bit k goes to stage k, bit 7 is the output stage |
| q_last_o | output | 1 | Value of the last stage |

## Verification
The bench loads a byte whose bits differ from their neighbours, so a design that reverses the bit order or loads the wrong lane would present the wrong sequence at the output. It feeds serial bits during the shift-out of the loaded byte, with stalls between them. A design that let a stalled edge move the data would then show the serial bits one place early. It also offers a new byte while in load mode but stalled: a design that loaded anyway would corrupt the output. Finally it asserts the clear mid-cycle and counts the edges after release, which catches a clear that waits for an edge and a release that is not synchronized or takes effect too early.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } piso_op_t;
endpackage

// File: rtl/piso_reset_sync.sv
module piso_reset_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_q_n
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[SYNC_STAGES-1];

  // R6: a clear seen at one edge keeps the internal reset active at the next
  a_r6_release_delay: assert property (@(posedge clk) !clr_n |=> !rst_q_n)
    else $error("internal reset released too early");
endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic     stall_i,
  input  logic     mode_shift_i,
  output piso_op_t op_o
);
  always_comb begin
    if (stall_i)           op_o = OP_HOLD;
    else if (mode_shift_i) op_o = OP_SHIFT;
    else                   op_o = OP_LOAD;
  end
endmodule

// File: rtl/piso_stage.sv
module piso_stage
  import piso_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  piso_op_t op_i,
  input  logic     prev_i,
  input  logic     par_i,
  output logic     q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= 1'b0;
    end else begin
      case (op_i)
        OP_SHIFT: q_o <= prev_i;
        OP_LOAD:  q_o <= par_i;
        default:  q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/piso_shift8.sv
module piso_shift8
  import piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             stall_i,
  input  logic             mode_shift_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             q_last_o
);
  localparam int LAST = WIDTH - 1;

  logic       rst_q_n;
  piso_op_t   op;
  logic [LAST:0] stage_q;

  piso_reset_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .clr_n   (clr_n),
    .rst_q_n (rst_q_n)
  );

  piso_ctrl u_ctrl (
    .stall_i      (stall_i),
    .mode_shift_i (mode_shift_i),
    .op_o         (op)
  );

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic prev;
    if (k == 0) begin : g_head
      assign prev = ser_i;
    end else begin : g_body
      assign prev = stage_q[k-1];
    end
    piso_stage u_stage (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .op_i   (op),
      .prev_i (prev),
      .par_i  (par_i[k]),
      .q_o    (stage_q[k])
    );
  end

  assign q_last_o = stage_q[LAST];

  // R2: stalled edge keeps the output
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_q_n)
    stall_i |=> $stable(q_last_o))
    else $error("output moved on a stalled edge");

  // R3: shift moves the next-to-last stage into the output
  a_r3_shift_advance: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!stall_i && mode_shift_i) |=> (q_last_o == $past(stage_q[LAST-1])))
    else $error("shift did not advance");

  // R4: load puts the top parallel bit on the output
  a_r4_load_last: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!stall_i && !mode_shift_i) |=> (q_last_o == $past(par_i[LAST])))
    else $error("load did not present top bit");

  // R1: clear holds the output low
  a_r1_clear_zero: assert property (@(posedge clk) !clr_n |-> (q_last_o == 1'b0))
    else $error("output not zero under clear");
endmodule

// File: tb/piso_shift8_tb_top.sv
module piso_shift8_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 20;

  typedef struct packed {
    logic       stall;
    logic       shift;
    logic       ser;
    logic [7:0] par;
    logic       exp_q;
  } vec_t;

  // byte 8'hB2 = 1011_0010; serial bits b1..b8 = 1,1,0,1,0,0,1,0
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b1, 8'hB2, 1'b1}, // R4 load, H=1, ser ignored
    '{1'b0, 1'b1, 1'b1, 8'h00, 1'b0}, // R3 G, b1
    '{1'b0, 1'b1, 1'b1, 8'h00, 1'b1}, // R3 F, b2
    '{1'b1, 1'b1, 1'b0, 8'h00, 1'b1}, // R2 stalled shift
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1}, // R3 E, b3
    '{1'b0, 1'b1, 1'b1, 8'h00, 1'b0}, // R3 D, b4
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b0}, // R3 C, b5
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1}, // R3 B, b6
    '{1'b1, 1'b0, 1'b0, 8'hFF, 1'b1}, // R2 stalled load
    '{1'b0, 1'b1, 1'b1, 8'h00, 1'b0}, // R3 A, b7
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1}, // R3 b8 in, b1 out
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1}, // R3 b2
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b0}, // R3 b3
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1}, // R3 b4
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b0}, // R3 b5
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b0}, // R3 b6
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1}, // R3 b7
    '{1'b0, 1'b1, 1'b0, 8'h00, 1'b0}, // R3 b8
    '{1'b0, 1'b0, 1'b1, 8'h80, 1'b1}, // R4 load top bit only
    '{1'b0, 1'b0, 1'b1, 8'h7F, 1'b0}  // R4 load all but top
  };

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       stall_i = 1'b1;
  logic       mode_shift_i = 1'b1;
  logic       ser_i = 1'b0;
  logic [7:0] par_i = 8'h00;
  logic       q_last_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  piso_shift8 dut_i (
    .clk          (clk),
    .clr_n        (clr_n),
    .stall_i      (stall_i),
    .mode_shift_i (mode_shift_i),
    .ser_i        (ser_i),
    .par_i        (par_i),
    .q_last_o     (q_last_o)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (q_last_o !== exp) begin
      failures++;
      $display("FAIL %s q_last_o=%b expected=%b at %0t", req, q_last_o, exp, $time);
    end
  endtask

  task automatic edge_then_sample();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #3;
    check("R1", 1'b0);
    repeat (3) @(posedge clk);
    #2;
    check("R1", 1'b0);
    @(negedge clk);
    clr_n = 1'b1;
    repeat (4) @(posedge clk);   // release absorbed, stalled anyway
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      stall_i      = VECS[i].stall;
      mode_shift_i = VECS[i].shift;
      ser_i        = VECS[i].ser;
      par_i        = VECS[i].par;
      edge_then_sample();
      if (VECS[i].stall)      check("R2", VECS[i].exp_q);
      else if (VECS[i].shift) check("R3", VECS[i].exp_q);
      else                    check("R4", VECS[i].exp_q);
    end
    // R5: clear mid-cycle after loading ones
    @(negedge clk);
    stall_i = 1'b0; mode_shift_i = 1'b0; par_i = 8'hFF;
    edge_then_sample();
    check("R4", 1'b1);
    #1;
    clr_n = 1'b0;
    #1;
    check("R5", 1'b0);
    // R6: release then count edges with load of ones pending
    @(negedge clk);
    clr_n = 1'b1;
    edge_then_sample();
    check("R6", 1'b0);
    edge_then_sample();
    check("R6", 1'b0);
    edge_then_sample();
    check("R6", 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule